// File: doc/BRIEF.md
# Static System Clock Controller with Stop and Slow Modes

This block turns one free-running input clock into three system clocks for a static processor. `clk_out` runs at one third of the input rate with a one-in-three high phase. `clk50_out` has the same period with a high phase of half the period. `pclk_out` is a peripheral clock at half the `clk_out` rate. A level input, `fast_sel`, picks full speed or a slow mode in which every period is stretched by a further factor `SLOW_DIV`. The slow request must be steady for `SLOW_HOLD` input cycles before it is accepted. Any mode change is applied only where one system clock period ends.

The processor can park the clocks by presenting a stop code on its status lines. After a stop, the clocks resume when `wake` goes high or `sys_res_n` goes low. With an external frequency source (`ext_src` high), the resume is immediate. With the block's own oscillator (`ext_src` low), the stop also drops `osc_en`. A resume then raises it again, waits for `sys_res_n` to be released, and counts `SETTLE` input cycles of oscillator settling before the clocks run.

The sequencer has four states:
- RUN: the clocks run.
- HALT: the clocks are parked high.
- WAIT_RES: the oscillator is re-enabled, and the sequencer waits for the restart reset to be released.
- SETTLE: the settling count runs.

The transitions are:
- RUN→HALT: the stop code is seen at the end of a period.
- HALT→RUN: a trigger arrives with the external source selected.
- HALT→WAIT_RES: a trigger arrives with the oscillator selected.
- WAIT_RES→SETTLE: `sys_res_n` is high.
- SETTLE→RUN: the count is done.

`sys_res_n`, `wake` and `fast_sel` each pass through a two-flop synchronizer before use.

Top module: `ccg_top`

## Requirements
- R1: In fast mode `clk_out` has a period of 3 input cycles and is high for exactly 1 of them.
- R2: `clk50_out` has the same period as `clk_out` and is high for 1.5 input cycles of each fast-mode period, resolved to half an input cycle.
- R3: `pclk_out` toggles once per `clk_out` period, giving a period of two `clk_out` periods with equal high and low time, in both modes.
- R4: In slow mode every phase lasts `SLOW_DIV` input cycles. `clk_out` is high for `SLOW_DIV` of every `3*SLOW_DIV` cycles, and `clk50_out` is high for `1.5*SLOW_DIV` of them.
- R5: Slow mode is entered only after `fast_sel` has been low for at least `SLOW_HOLD` consecutive input cycles. A shorter low pulse has no effect on the clocks. A high level on `fast_sel` returns the block to fast mode.
- R6: Mode changes happen only at the end of a `clk_out` period, which is also a `pclk_out` edge. `clk_out` never shows a high run other than 1 or `SLOW_DIV` input cycles, nor a low run other than 2 or `2*SLOW_DIV` cycles.
- R7: `cpu_stat` is read as {s2,s1,s0} at each `clk_out` rising edge. Code 3'b011 parks all three clocks high. Any other code has no effect.
- R8: While parked with `ext_src` low, `osc_en` is 0. With `ext_src` high it stays 1.
- R9: With `ext_src` high, a trigger (`wake` high or `sys_res_n` low) restarts the clocks. `clk_out` falls within 8 input cycles of the trigger, and fast operation follows.
- R10: With `ext_src` low, a trigger raises `osc_en`. The clocks stay high while `sys_res_n` is low and for at least `SETTLE` input cycles after it is high. They resume within `SETTLE+8` cycles.
- R11: While `rst_n` is low, all three clocks and `osc_en` are 1 and the block is in fast mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Free-running input clock (oscillator or external source) |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ext_src | input | 1 | 1: external frequency source, 0: own oscillator |
| sys_res_n | input | 1 | Active-low restart reset, asynchronous |
| wake | input | 1 | Restart request, asynchronous |
| fast_sel | input | 1 | 1: fast mode, 0: slow request, asynchronous |
| cpu_stat | input | 3 | Processor status {s2,s1,s0}, synchronous to clk_out |
| clk_out | output | 1 | System clock, one-third duty |
| clk50_out | output | 1 | System clock, half duty |
| pclk_out | output | 1 | Peripheral clock at half the system rate |
| osc_en | output | 1 | Oscillator enable |

## Verification
The bench builds the block with `SLOW_DIV`=4, `SLOW_HOLD`=6 and `SETTLE`=20. With these values, a slow period of 12 input cycles fits into short windows, and a glitch of 5 cycles falls just under the filter length. The settling wait can be timed to the cycle from the release of `sys_res_n` without running thousands of cycles. The same small values let one run cover the following: both mode transitions with the runt-pulse monitor active, stops under both clock sources, and restarts from both trigger inputs.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_HALT,
        ST_WAIT_RES,
        ST_SETTLE
    } seq_state_t;

    localparam logic [2:0] STOP_CODE = 3'b011;
endpackage

// File: rtl/ccg_sync.sv
module ccg_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[i] <= INIT[i];
                q[i]    <= INIT[i];
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/ccg_mode_filter.sv
module ccg_mode_filter #(
    parameter int SLOW_HOLD = 195
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_s,
    output logic slow_req
);
    localparam int CW = $clog2(SLOW_HOLD + 1);
    localparam logic [CW-1:0] CMAX = CW'(SLOW_HOLD);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (fast_s) begin
            low_cnt <= '0;
        end else if (low_cnt != CMAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign slow_req = (low_cnt == CMAX);
endmodule

// File: rtl/ccg_divider.sv
module ccg_divider #(
    parameter int SLOW_DIV = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       slow_req,
    output logic [2:0] ph,
    output logic       slow,
    output logic       end_per,
    output logic       c50_raw,
    output logic       pclk_raw
);
    localparam int PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PW-1:0] PMAX  = PW'(SLOW_DIV - 1);
    localparam logic [PW-1:0] PHALF = PW'(SLOW_DIV / 2);

    logic [PW-1:0] pre;
    logic          tick;
    logic          c50_n;
    logic          pclk_r;

    assign tick    = !slow || (pre == PMAX);
    assign end_per = run && tick && ph[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph     <= 3'b001;
            pre    <= '0;
            pclk_r <= 1'b1;
            slow   <= 1'b0;
        end else if (!run) begin
            ph     <= 3'b001;
            pre    <= '0;
            pclk_r <= 1'b1;
        end else if (tick) begin
            pre <= '0;
            ph  <= {ph[1:0], ph[2]};
            if (ph[2]) begin
                pclk_r <= ~pclk_r;
                slow   <= slow_req;
            end
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // half-cycle extension of the high phase in fast mode
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c50_n <= 1'b0;
        end else begin
            c50_n <= ph[0] & ~slow;
        end
    end

    assign c50_raw  = ph[0] | c50_n | (slow & ph[1] & (pre < PHALF));
    assign pclk_raw = pclk_r;
endmodule

// File: rtl/ccg_restart_seq.sv
module ccg_restart_seq
    import ccg_pkg::*;
#(
    parameter int SETTLE = 8192
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            end_per,
    input  logic [2:0]      stat,
    input  logic            ext_src,
    input  logic            wake_s,
    input  logic            res_s,
    output logic            run,
    output logic            osc_en,
    output seq_state_t      state,
    output logic [$clog2(SETTLE)-1:0] cnt
);
    localparam int CW = $clog2(SETTLE);
    localparam logic [CW-1:0] SMAX = CW'(SETTLE - 1);

    seq_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:      if (end_per && stat == STOP_CODE) nxt = ST_HALT;
            ST_HALT:     if (wake_s || !res_s) nxt = ext_src ? ST_RUN : ST_WAIT_RES;
            ST_WAIT_RES: if (res_s) nxt = ST_SETTLE;
            ST_SETTLE:   if (cnt == SMAX) nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_SETTLE) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        run    = (state == ST_RUN);
        osc_en = !((state == ST_HALT) && !ext_src);
    end
endmodule

// File: rtl/ccg_top.sv
module ccg_top
    import ccg_pkg::*;
#(
    parameter int SLOW_DIV  = 256,
    parameter int SLOW_HOLD = 195,
    parameter int SETTLE    = 8192
) (
    input  logic       clk_in,
    input  logic       rst_n,
    input  logic       ext_src,
    input  logic       sys_res_n,
    input  logic       wake,
    input  logic       fast_sel,
    input  logic [2:0] cpu_stat,
    output logic       clk_out,
    output logic       clk50_out,
    output logic       pclk_out,
    output logic       osc_en
);
    localparam int CW = $clog2(SETTLE);

    logic [2:0]  sync_q;
    logic        res_s, wake_s, fast_s;
    logic        slow_req;
    logic [2:0]  ph;
    logic        slow, end_per, c50_raw, pclk_raw;
    logic        run;
    seq_state_t  state;
    logic [CW-1:0] settle_cnt;

    ccg_sync #(.W(3), .INIT(3'b101)) u_sync (
        .clk(clk_in), .rst_n(rst_n),
        .d({sys_res_n, wake, fast_sel}),
        .q(sync_q)
    );
    assign {res_s, wake_s, fast_s} = sync_q;

    ccg_mode_filter #(.SLOW_HOLD(SLOW_HOLD)) u_filt (
        .clk(clk_in), .rst_n(rst_n), .fast_s(fast_s), .slow_req(slow_req)
    );

    ccg_divider #(.SLOW_DIV(SLOW_DIV)) u_div (
        .clk(clk_in), .rst_n(rst_n), .run(run), .slow_req(slow_req),
        .ph(ph), .slow(slow), .end_per(end_per),
        .c50_raw(c50_raw), .pclk_raw(pclk_raw)
    );

    ccg_restart_seq #(.SETTLE(SETTLE)) u_seq (
        .clk(clk_in), .rst_n(rst_n), .end_per(end_per), .stat(cpu_stat),
        .ext_src(ext_src), .wake_s(wake_s), .res_s(res_s),
        .run(run), .osc_en(osc_en), .state(state), .cnt(settle_cnt)
    );

    assign clk_out   = ph[0]    | ~run;
    assign clk50_out = c50_raw  | ~run;
    assign pclk_out  = pclk_raw | ~run;
endmodule

// File: rtl/ccg_chk.sv
module ccg_chk
    import ccg_pkg::*;
#(
    parameter int SETTLE = 8192
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ph,
    input logic       slow,
    input logic       slow_req,
    input logic       end_per,
    input logic       run,
    input logic [2:0] stat,
    input logic       osc_en,
    input seq_state_t state,
    input logic [$clog2(SETTLE)-1:0] cnt
);
    localparam int CW = $clog2(SETTLE);
    localparam logic [CW-1:0] SMAX = CW'(SETTLE - 1);

    // R1: exactly one phase active
    a_r1_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ph) == 1);

    // R6: mode register moves only at a period end
    a_r6_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slow) |-> $past(end_per));

    // R5: slow entry only after the filter accepted it
    a_r5_slow_needs_filter: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow) |-> $past(slow_req));

    // R7: stop code at a period end parks the clocks
    a_r7_halt_on_code: assert property (@(posedge clk) disable iff (!rst_n)
        (run && end_per && stat == STOP_CODE) |=> !run);

    // R7: no other condition stops running clocks
    a_r7_no_false_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(end_per && stat == STOP_CODE)) |=> run);

    // R10: leaving the settle wait only after the full count
    a_r10_settle_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && run == 1'b0) |=> (run -> $past(cnt) == SMAX));

    // R8: oscillator is off only while parked
    a_r8_osc_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !run);
endmodule

bind ccg_top ccg_chk #(.SETTLE(SETTLE)) u_chk (
    .clk(clk_in), .rst_n(rst_n), .ph(ph), .slow(slow), .slow_req(slow_req),
    .end_per(end_per), .run(run), .stat(cpu_stat), .osc_en(osc_en),
    .state(state), .cnt(settle_cnt)
);

// File: tb/tb_ccg_top.sv
module tb_ccg_top;
    localparam int SD = 4;
    localparam int SH = 6;
    localparam int ST = 20;

    logic clk_in = 1'b0;
    logic rst_n = 1'b0;
    logic ext_src = 1'b1;
    logic sys_res_n = 1'b1;
    logic wake = 1'b0;
    logic fast_sel = 1'b1;
    logic [2:0] cpu_stat = 3'b000;
    logic clk_out, clk50_out, pclk_out, osc_en;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk_in = ~clk_in;

    ccg_top #(.SLOW_DIV(SD), .SLOW_HOLD(SH), .SETTLE(ST)) dut (
        .clk_in(clk_in), .rst_n(rst_n), .ext_src(ext_src), .sys_res_n(sys_res_n),
        .wake(wake), .fast_sel(fast_sel), .cpu_stat(cpu_stat),
        .clk_out(clk_out), .clk50_out(clk50_out), .pclk_out(pclk_out), .osc_en(osc_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // runt monitor for clk_out run lengths in half cycles
    bit mon_en = 0;
    int runts = 0;
    bit started = 0, first_run = 0, lastv = 0;
    int runlen = 0;
    always @(edge clk_in) begin
        #1;
        if (!mon_en) begin
            started = 0;
        end else if (!started) begin
            started = 1; first_run = 1; lastv = clk_out; runlen = 0;
        end else if (clk_out == lastv) begin
            runlen++;
        end else begin
            if (!first_run) begin
                if (lastv && !(runlen == 2 || runlen == 2*SD)) runts++;
                if (!lastv && !(runlen == 4 || runlen == 4*SD)) runts++;
            end
            first_run = 0; lastv = clk_out; runlen = 1;
        end
    end

    task automatic measure(input int halves, output int hc, output int h5,
                           output int hp, output int rc, output int rp);
        bit pc, pp;
        hc = 0; h5 = 0; hp = 0; rc = 0; rp = 0;
        @(edge clk_in); #1;
        pc = clk_out; pp = pclk_out;
        for (int i = 0; i < halves; i++) begin
            @(edge clk_in); #1;
            hc += int'(clk_out); h5 += int'(clk50_out); hp += int'(pclk_out);
            if (clk_out && !pc) rc++;
            if (pclk_out && !pp) rp++;
            pc = clk_out; pp = pclk_out;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk_in);
    endtask

    task automatic fall_wait(input int maxc, output int n);
        n = 0;
        while (n < maxc) begin
            @(negedge clk_in); n++;
            if (!clk_out) break;
        end
    endtask

    task automatic check_fast(input string req);
        int hc, h5, hp, rc, rp;
        measure(24, hc, h5, hp, rc, rp);
        chk(hc == 8, req, "clk high halves", hc, 8);
        chk(rc == 4, req, "clk rises", rc, 4);
        chk(h5 == 12, req, "clk50 high halves", h5, 12);
        chk(rp == 2 && hp == 12, req, "pclk rises", rp, 2);
    endtask

    task automatic t_reset;
        #15;
        chk({clk_out, clk50_out, pclk_out, osc_en} == 4'hF, "R11", "reset outputs",
            int'({clk_out, clk50_out, pclk_out, osc_en}), 15);
        @(negedge clk_in); rst_n = 1'b1;
        cycles(6);
    endtask

    task automatic t_fast;
        check_fast("R1");
        check_fast("R2");
    endtask

    task automatic t_glitch;
        @(negedge clk_in); fast_sel = 1'b0;
        cycles(SH - 1);
        fast_sel = 1'b1;
        cycles(10);
        check_fast("R5");
    endtask

    task automatic t_slow;
        int hc, h5, hp, rc, rp;
        mon_en = 1;
        @(negedge clk_in); fast_sel = 1'b0;
        cycles(40);
        measure(48, hc, h5, hp, rc, rp);
        chk(hc == 16, "R4", "slow clk high halves", hc, 16);
        chk(h5 == 24, "R4", "slow clk50 high halves", h5, 24);
        chk(rc == 2, "R4", "slow clk rises", rc, 2);
        chk(rp == 1 && hp == 24, "R3", "slow pclk rises", rp, 1);
    endtask

    task automatic t_back_fast;
        @(negedge clk_in); fast_sel = 1'b1;
        cycles(30);
        check_fast("R5");
        chk(runts == 0, "R6", "runt pulses across mode changes", runts, 0);
        mon_en = 0;
    endtask

    task automatic t_other_codes;
        @(negedge clk_in); cpu_stat = 3'b001; cycles(6);
        cpu_stat = 3'b111; cycles(6);
        cpu_stat = 3'b010; cycles(6);
        check_fast("R7");
        cpu_stat = 3'b000;
    endtask

    task automatic t_halt(input bit ext, input string req);
        int hc, h5, hp, rc, rp;
        @(negedge clk_in); ext_src = ext; cpu_stat = 3'b011;
        cycles(8);
        cpu_stat = 3'b000;
        measure(24, hc, h5, hp, rc, rp);
        chk(hc == 24 && h5 == 24 && hp == 24, "R7", "parked clocks high", hc + h5 + hp, 72);
        chk(osc_en == ext, req, "osc_en while parked", int'(osc_en), int'(ext));
    endtask

    task automatic t_restart_ext;
        int n;
        @(negedge clk_in); wake = 1'b1;
        fall_wait(8, n);
        wake = 1'b0;
        chk(!clk_out, "R9", "clk falls after wake", int'(clk_out), 0);
        check_fast("R9");
    endtask

    task automatic t_restart_res;
        int hc, h5, hp, rc, rp, n;
        @(negedge clk_in); sys_res_n = 1'b0;
        cycles(4);
        chk(osc_en == 1'b1, "R10", "osc_en after trigger", int'(osc_en), 1);
        measure(60, hc, h5, hp, rc, rp);
        chk(hc == 60, "R10", "clk high while restart reset held", hc, 60);
        @(negedge clk_in); sys_res_n = 1'b1;
        measure(2*ST - 1, hc, h5, hp, rc, rp);
        chk(hc == 2*ST - 1, "R10", "clk high during settle", hc, 2*ST - 1);
        fall_wait(10, n);
        chk(!clk_out, "R10", "clk resumes after settle", int'(clk_out), 0);
        check_fast("R10");
    endtask

    task automatic t_restart_wake_osc;
        int n;
        @(negedge clk_in); wake = 1'b1;
        cycles(2); wake = 1'b0;
        fall_wait(ST + 8, n);
        n += 2;
        chk(!clk_out && n >= ST && n <= ST + 8, "R10", "wake restart latency", n, ST + 5);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fast();
        t_glitch();
        t_slow();
        t_back_fast();
        t_other_codes();
        t_halt(1'b1, "R8");
        t_restart_ext();
        t_halt(1'b0, "R8");
        t_restart_res();
        t_halt(1'b0, "R8");
        t_restart_wake_osc();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule